// File: doc/BRIEF.md
# Memory Error Logger and Interrupt Word

This unit sits beside a memory controller and records what goes wrong. Each read that the external ECC decoder checks arrives as one cycle with a correctable or uncorrectable flag, the raw 64-bit data, the check byte and the address. An uncorrectable error always raises a high-priority machine check. A correctable error is reported, with a low-priority machine check, only while software has enabled low-priority machine checks. Each reported error overwrites a set of capture registers, so these always hold the most recent one. Sticky status flags collect these errors and several other fault events until software writes the status register.

The unit also guards memory bounds. A programmed limit, kept only to a 4 MiB granule, flags every non-I/O access at or above it as a CPU address error. Separately, software programs an interrupt word. Each time the active-low external interrupt line falls, the unit sends that word to the CPU for one cycle, to be ORed into its pending-interrupt register. A command reset input restarts the unit as a hard reset would, and leaves a flag that records the cause.

Top module: `mem_err_logger`

## Requirements
- R1: After the asynchronous reset, all status flags read 0, status bits [31:8] read the REV parameter, control reads 0, the limit reads 0xFFC00000, the interrupt word and capture registers read 0, and hpmc, lpmc, acc_err and eir_valid are low.
- R2: A checked read with chk_hard set pulses hpmc for exactly the next cycle, sets hard flag (status bit 0) and updates the capture registers, whatever the enable bit (control bit 0) holds.
- R3: A checked read with only chk_soft set, while control bit 0 is 0, leaves lpmc low, leaves soft flag (status bit 1) clear and leaves the capture registers unchanged. While control bit 0 is 1, it pulses lpmc for one cycle, sets status bit 1 and updates the capture registers.
- R4: The capture registers hold the last reported error: address 4 reads data[63:32], address 5 reads data[31:0], address 6 reads the check byte in bits [7:0], and address 7 reads the error address. A later reported error overwrites all four.
- R5: Status bits 0 to 6 are sticky. Any write to status (address 1) clears them, but an event in the same cycle as the write still sets its bit.
- R6: The limit (address 3) keeps write bits [31:22] and reads 0 in bits [21:0]. An access with acc_io low and acc_addr at or above the limit pulses acc_err in the next cycle and sets CPU address error (status bit 2). An I/O access, or one below the limit, does neither.
- R7: A high-to-low transition of irq_n drives eir_valid high for one cycle, with eir_word equal to the interrupt word (address 2). A steady level or a rising edge sends nothing.
- R8: A cmd_rst pulse returns every register to its R1 value and then sets the command-reset flag (status bit 7). A status write leaves bit 7 unchanged, and only the asynchronous reset clears it.
- R9: The event inputs set their own sticky flags: ev_grf_ader sets bit 3, ev_vid_tmo sets bit 4, ev_vid_ader sets bit 5, ev_toc sets bit 6, and ev_cpu_tmo sets bit 2.
- R10: Writes to the capture registers (addresses 4 to 7) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_rst | input | 1 | Synchronous command reset pulse |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| chk_valid | input | 1 | ECC check result present |
| chk_soft | input | 1 | Correctable error |
| chk_hard | input | 1 | Uncorrectable error |
| chk_data | input | 64 | Raw double word |
| chk_ckbyte | input | 8 | Raw check byte |
| chk_addr | input | 32 | Address of the checked read |
| acc_valid | input | 1 | Memory access present |
| acc_io | input | 1 | Access targets I/O space |
| acc_addr | input | 32 | Access address |
| acc_err | output | 1 | Access beyond limit, one-cycle pulse |
| ev_grf_ader | input | 1 | Graphics address error event |
| ev_cpu_tmo | input | 1 | CPU timeout event |
| ev_vid_tmo | input | 1 | Video engine timeout event |
| ev_vid_ader | input | 1 | Video engine address error event |
| ev_toc | input | 1 | Transfer-of-control event |
| hpmc | output | 1 | High-priority machine check pulse |
| lpmc | output | 1 | Low-priority machine check pulse |
| irq_n | input | 1 | Active-low external interrupt line |
| eir_valid | output | 1 | Interrupt word strobe |
| eir_word | output | 32 | Interrupt word to OR into the CPU register |

## Verification
Internal faults in this unit show at the ports no more than one cycle after the stimulus. A wrong enable or class decode appears on hpmc or lpmc on the cycle after the check, and in the status readback at once. A stale or mis-enabled capture shows up as wrong words at addresses 4 to 7 right after an error is suppressed or overwritten. A wrong edge history shows up as a missing or extra eir_valid strobe next to a change of irq_n. A wrongly truncated limit shows up as an acc_err on the wrong side of the table's boundary addresses.

// File: rtl/mel_pkg.sv
package mel_pkg;
  localparam int unsigned REG_AW = 3;
  localparam int unsigned NFLAGS = 8;

  localparam logic [REG_AW-1:0] RA_CTRL     = 3'd0;
  localparam logic [REG_AW-1:0] RA_STAT     = 3'd1;
  localparam logic [REG_AW-1:0] RA_IWORD    = 3'd2;
  localparam logic [REG_AW-1:0] RA_LIMIT    = 3'd3;
  localparam logic [REG_AW-1:0] RA_LOG_HI   = 3'd4;
  localparam logic [REG_AW-1:0] RA_LOG_LO   = 3'd5;
  localparam logic [REG_AW-1:0] RA_LOG_CK   = 3'd6;
  localparam logic [REG_AW-1:0] RA_LOG_ADDR = 3'd7;

  localparam int unsigned FL_HARD   = 0;
  localparam int unsigned FL_SOFT   = 1;
  localparam int unsigned FL_CPU    = 2;
  localparam int unsigned FL_GRF    = 3;
  localparam int unsigned FL_VTMO   = 4;
  localparam int unsigned FL_VADER  = 5;
  localparam int unsigned FL_TOC    = 6;
  localparam int unsigned FL_CMDRST = 7;

  typedef logic [NFLAGS-1:0] flags_t;
endpackage

// File: rtl/mel_ecc_log.sv
module mel_ecc_log #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CK_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              lpmc_en,
  input  logic              chk_valid,
  input  logic              chk_soft,
  input  logic              chk_hard,
  input  logic [DATA_W-1:0] chk_data,
  input  logic [CK_W-1:0]   chk_ckbyte,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic              hard_evt,
  output logic              soft_evt,
  output logic              hpmc,
  output logic              lpmc,
  output logic [DATA_W-1:0] log_data,
  output logic [CK_W-1:0]   log_ck,
  output logic [ADDR_W-1:0] log_addr
);
  logic              cap_en;
  logic              hpmc_d, lpmc_d;
  logic [DATA_W-1:0] data_d;
  logic [CK_W-1:0]   ck_d;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    hard_evt = chk_valid & chk_hard;
    soft_evt = chk_valid & chk_soft & ~chk_hard & lpmc_en;
    cap_en   = hard_evt | soft_evt;
    hpmc_d   = hard_evt & ~clr;
    lpmc_d   = soft_evt & ~clr;
    data_d   = log_data;
    ck_d     = log_ck;
    addr_d   = log_addr;
    if (clr) begin
      data_d = '0;
      ck_d   = '0;
      addr_d = '0;
    end else if (cap_en) begin
      data_d = chk_data;
      ck_d   = chk_ckbyte;
      addr_d = chk_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hpmc     <= 1'b0;
      lpmc     <= 1'b0;
      log_data <= '0;
      log_ck   <= '0;
      log_addr <= '0;
    end else begin
      hpmc     <= hpmc_d;
      lpmc     <= lpmc_d;
      log_data <= data_d;
      log_ck   <= ck_d;
      log_addr <= addr_d;
    end
  end

  AST_HPMC_ON_HARD: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_valid && chk_hard && !clr) |=> hpmc); // R2
  AST_NO_LPMC_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!lpmc_en || !chk_valid) |=> !lpmc); // R3
  AST_LOG_HELD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!chk_valid && !clr) |=> $stable(log_addr)); // R4
endmodule

// File: rtl/mel_limit.sv
module mel_limit #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IGN    = 22
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  wr_en,
  input  logic [ADDR_W-IGN-1:0] wr_hi,
  input  logic                  acc_valid,
  input  logic                  acc_io,
  input  logic [ADDR_W-1:0]     acc_addr,
  output logic [ADDR_W-1:0]     limit_val,
  output logic                  viol,
  output logic                  acc_err
);
  localparam int unsigned KEEP_W = ADDR_W - IGN;

  logic [KEEP_W-1:0] lim_q, lim_d;
  logic              err_d;

  always_comb begin
    limit_val = {lim_q, {IGN{1'b0}}};
    viol      = acc_valid & ~acc_io & (acc_addr >= limit_val);
    err_d     = viol & ~clr;
    lim_d     = lim_q;
    if (clr)        lim_d = '1;
    else if (wr_en) lim_d = wr_hi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q   <= '1;
      acc_err <= 1'b0;
    end else begin
      lim_q   <= lim_d;
      acc_err <= err_d;
    end
  end

  AST_ACC_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> $past(acc_valid && !acc_io)); // R6
  AST_IO_NEVER_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_io) |=> !acc_err); // R6
endmodule

// File: rtl/mel_edge_irq.sv
module mel_edge_irq #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         irq_n,
  output logic [W-1:0] word,
  output logic         eir_valid,
  output logic [W-1:0] eir_word
);
  logic         prev_q, prev_d;
  logic         fall;
  logic [W-1:0] word_d, out_d;
  logic         valid_d;

  always_comb begin
    fall    = prev_q & ~irq_n;
    prev_d  = clr ? 1'b0 : irq_n;
    valid_d = fall & ~clr;
    out_d   = valid_d ? word : '0;
    word_d  = word;
    if (clr)        word_d = '0;
    else if (wr_en) word_d = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q    <= 1'b0;
      word      <= '0;
      eir_valid <= 1'b0;
      eir_word  <= '0;
    end else begin
      prev_q    <= prev_d;
      word      <= word_d;
      eir_valid <= valid_d;
      eir_word  <= out_d;
    end
  end

  AST_EIR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    eir_valid |=> !eir_valid); // R7
  AST_EIR_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    eir_valid |-> !$past(irq_n)); // R7
  AST_EIR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !eir_valid |-> (eir_word == '0)); // R7
endmodule

// File: rtl/mem_err_logger.sv
module mem_err_logger
  import mel_pkg::*;
#(
  parameter logic [23:0] REV       = 24'h00A51C,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned CK_W      = 8,
  parameter int unsigned LIMIT_IGN = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_rst,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              chk_valid,
  input  logic              chk_soft,
  input  logic              chk_hard,
  input  logic [DATA_W-1:0] chk_data,
  input  logic [CK_W-1:0]   chk_ckbyte,
  input  logic [ADDR_W-1:0] chk_addr,
  input  logic              acc_valid,
  input  logic              acc_io,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              acc_err,
  input  logic              ev_grf_ader,
  input  logic              ev_cpu_tmo,
  input  logic              ev_vid_tmo,
  input  logic              ev_vid_ader,
  input  logic              ev_toc,
  output logic              hpmc,
  output logic              lpmc,
  input  logic              irq_n,
  output logic              eir_valid,
  output logic [31:0]       eir_word
);
  localparam int unsigned HALF = DATA_W / 2;

  logic              ctrl_q, ctrl_d;
  flags_t            flags_q, flags_d, set_v;
  logic              wr_ctrl, wr_stat, wr_iword, wr_limit;
  logic              hard_evt, soft_evt, viol;
  logic [DATA_W-1:0] log_data;
  logic [CK_W-1:0]   log_ck;
  logic [ADDR_W-1:0] log_addr, limit_val;
  logic [31:0]       iword;

  always_comb begin
    wr_ctrl  = reg_we && (reg_addr == RA_CTRL);
    wr_stat  = reg_we && (reg_addr == RA_STAT);
    wr_iword = reg_we && (reg_addr == RA_IWORD);
    wr_limit = reg_we && (reg_addr == RA_LIMIT);
  end

  mel_ecc_log #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CK_W(CK_W)) u_log (
    .clk(clk), .rst_n(rst_n), .clr(cmd_rst), .lpmc_en(ctrl_q),
    .chk_valid(chk_valid), .chk_soft(chk_soft), .chk_hard(chk_hard),
    .chk_data(chk_data), .chk_ckbyte(chk_ckbyte), .chk_addr(chk_addr),
    .hard_evt(hard_evt), .soft_evt(soft_evt), .hpmc(hpmc), .lpmc(lpmc),
    .log_data(log_data), .log_ck(log_ck), .log_addr(log_addr)
  );

  mel_limit #(.ADDR_W(ADDR_W), .IGN(LIMIT_IGN)) u_lim (
    .clk(clk), .rst_n(rst_n), .clr(cmd_rst), .wr_en(wr_limit),
    .wr_hi(reg_wdata[ADDR_W-1:LIMIT_IGN]),
    .acc_valid(acc_valid), .acc_io(acc_io), .acc_addr(acc_addr),
    .limit_val(limit_val), .viol(viol), .acc_err(acc_err)
  );

  mel_edge_irq #(.W(32)) u_irq (
    .clk(clk), .rst_n(rst_n), .clr(cmd_rst), .wr_en(wr_iword),
    .wr_data(reg_wdata), .irq_n(irq_n), .word(iword),
    .eir_valid(eir_valid), .eir_word(eir_word)
  );

  always_comb begin
    set_v            = '0;
    set_v[FL_HARD]   = hard_evt;
    set_v[FL_SOFT]   = soft_evt;
    set_v[FL_CPU]    = viol | ev_cpu_tmo;
    set_v[FL_GRF]    = ev_grf_ader;
    set_v[FL_VTMO]   = ev_vid_tmo;
    set_v[FL_VADER]  = ev_vid_ader;
    set_v[FL_TOC]    = ev_toc;
    flags_d = flags_q;
    if (wr_stat) flags_d[FL_CMDRST-1:0] = '0;
    flags_d = flags_d | set_v;
    ctrl_d  = wr_ctrl ? reg_wdata[0] : ctrl_q;
    if (cmd_rst) begin
      flags_d             = '0;
      flags_d[FL_CMDRST]  = 1'b1;
      ctrl_d              = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      ctrl_q  <= 1'b0;
    end else begin
      flags_q <= flags_d;
      ctrl_q  <= ctrl_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CTRL:     reg_rdata[0] = ctrl_q;
      RA_STAT:     reg_rdata = {REV, flags_q};
      RA_IWORD:    reg_rdata = iword;
      RA_LIMIT:    reg_rdata = limit_val;
      RA_LOG_HI:   reg_rdata = log_data[DATA_W-1:HALF];
      RA_LOG_LO:   reg_rdata = log_data[HALF-1:0];
      RA_LOG_CK:   reg_rdata[CK_W-1:0] = log_ck;
      default:     reg_rdata = log_addr;
    endcase
  end

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_stat && !cmd_rst) |=> ((flags_q & $past(flags_q)) == $past(flags_q))); // R5
  AST_CMDRST_SET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rst |=> (flags_q == 8'h80)); // R8
  AST_CMDRST_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_rst) |=> (flags_q[FL_CMDRST] == $past(flags_q[FL_CMDRST]))); // R8
endmodule

// File: tb/test_mem_err_logger.sv
`timescale 1ns/1ps
module test_mem_err_logger;
  localparam logic [23:0] REV = 24'h00A51C;

  logic clk = 1'b0;
  logic rst_n, cmd_rst, reg_we;
  logic [2:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic chk_valid, chk_soft, chk_hard;
  logic [63:0] chk_data;
  logic [7:0] chk_ckbyte;
  logic [31:0] chk_addr;
  logic acc_valid, acc_io, acc_err;
  logic [31:0] acc_addr;
  logic ev_grf_ader, ev_cpu_tmo, ev_vid_tmo, ev_vid_ader, ev_toc;
  logic hpmc, lpmc, irq_n, eir_valid;
  logic [31:0] eir_word;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mem_err_logger #(.REV(REV)) i_mem_err_logger (
    .clk(clk), .rst_n(rst_n), .cmd_rst(cmd_rst), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .chk_valid(chk_valid), .chk_soft(chk_soft), .chk_hard(chk_hard),
    .chk_data(chk_data), .chk_ckbyte(chk_ckbyte), .chk_addr(chk_addr),
    .acc_valid(acc_valid), .acc_io(acc_io), .acc_addr(acc_addr), .acc_err(acc_err),
    .ev_grf_ader(ev_grf_ader), .ev_cpu_tmo(ev_cpu_tmo), .ev_vid_tmo(ev_vid_tmo),
    .ev_vid_ader(ev_vid_ader), .ev_toc(ev_toc), .hpmc(hpmc), .lpmc(lpmc),
    .irq_n(irq_n), .eir_valid(eir_valid), .eir_word(eir_word)
  );

  // {io, addr, expected acc_err} with limit 0x40000000
  localparam logic [33:0] LIM_TAB [7] = '{
    {1'b0, 32'h3FFF_FFFF, 1'b0},
    {1'b0, 32'h4000_0000, 1'b1},
    {1'b0, 32'h7FFF_FFFF, 1'b1},
    {1'b1, 32'h8000_0000, 1'b0},
    {1'b0, 32'h0000_0000, 1'b0},
    {1'b0, 32'hFFFF_FFFF, 1'b1},
    {1'b0, 32'h4012_3456, 1'b1}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic ecc(input logic s, input logic h, input logic [63:0] d,
                     input logic [7:0] c, input logic [31:0] a);
    @(negedge clk);
    chk_valid = 1'b1; chk_soft = s; chk_hard = h;
    chk_data = d; chk_ckbyte = c; chk_addr = a;
    @(negedge clk);
    chk_valid = 1'b0; chk_soft = 1'b0; chk_hard = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; cmd_rst = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    chk_valid = 1'b0; chk_soft = 1'b0; chk_hard = 1'b0;
    chk_data = '0; chk_ckbyte = '0; chk_addr = '0;
    acc_valid = 1'b0; acc_io = 1'b0; acc_addr = '0;
    ev_grf_ader = 1'b0; ev_cpu_tmo = 1'b0; ev_vid_tmo = 1'b0;
    ev_vid_ader = 1'b0; ev_toc = 1'b0; irq_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd1, v); chk("R1 status", v, {REV, 8'h00});
    rd(3'd0, v); chk("R1 ctrl", v, 32'h0);
    rd(3'd3, v); chk("R1 limit", v, 32'hFFC0_0000);
    rd(3'd2, v); chk("R1 iword", v, 32'h0);
    rd(3'd7, v); chk("R1 log addr", v, 32'h0);
    chk("R1 outputs", {hpmc, lpmc, acc_err, eir_valid}, 4'b0);

    // R6 limit truncation and table of accesses
    wr(3'd3, 32'h4012_3456);
    rd(3'd3, v); chk("R6 limit low bits", v, 32'h4000_0000);
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      acc_valid = 1'b1; acc_io = LIM_TAB[i][33]; acc_addr = LIM_TAB[i][32:1];
      @(negedge clk);
      acc_valid = 1'b0;
      chk("R6 acc_err", acc_err, LIM_TAB[i][0]);
      rd(3'd1, v); chk("R6 cpu flag", v[2], LIM_TAB[i][0]);
      wr(3'd1, 32'h0);
    end

    // R3 soft error suppressed when disabled
    ecc(1'b1, 1'b0, 64'h0123_4567_89AB_CDEF, 8'h11, 32'h0000_0500);
    chk("R3 lpmc off", lpmc, 1'b0);
    rd(3'd1, v); chk("R3 soft flag off", v[1], 1'b0);
    rd(3'd7, v); chk("R3 log untouched", v, 32'h0);
    rd(3'd5, v); chk("R3 log lo untouched", v, 32'h0);

    // R3 soft error reported when enabled, R4 capture
    wr(3'd0, 32'h1);
    ecc(1'b1, 1'b0, 64'h1122_3344_5566_7788, 8'hA5, 32'h0000_1000);
    chk("R3 lpmc on", lpmc, 1'b1);
    chk("R3 no hpmc", hpmc, 1'b0);
    @(negedge clk);
    chk("R3 lpmc one cycle", lpmc, 1'b0);
    rd(3'd1, v); chk("R3 soft flag", v[1:0], 2'b10);
    rd(3'd4, v); chk("R4 hi", v, 32'h1122_3344);
    rd(3'd5, v); chk("R4 lo", v, 32'h5566_7788);
    rd(3'd6, v); chk("R4 ck", v, 32'h0000_00A5);
    rd(3'd7, v); chk("R4 addr", v, 32'h0000_1000);

    // R2 hard error with enable off, overwrites log (R4)
    wr(3'd0, 32'h0);
    ecc(1'b0, 1'b1, 64'hDEAD_BEEF_CAFE_F00D, 8'h3C, 32'h0000_2000);
    chk("R2 hpmc", hpmc, 1'b1);
    chk("R2 no lpmc", lpmc, 1'b0);
    @(negedge clk);
    chk("R2 hpmc one cycle", hpmc, 1'b0);
    rd(3'd1, v); chk("R2 hard flag", v[1:0], 2'b11);
    rd(3'd4, v); chk("R4 overwrite hi", v, 32'hDEAD_BEEF);
    rd(3'd5, v); chk("R4 overwrite lo", v, 32'hCAFE_F00D);
    rd(3'd6, v); chk("R4 overwrite ck", v, 32'h0000_003C);
    rd(3'd7, v); chk("R4 overwrite addr", v, 32'h0000_2000);

    // R5 clear with simultaneous event
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'd1; reg_wdata = 32'h0; ev_toc = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; ev_toc = 1'b0;
    rd(3'd1, v); chk("R5 clear with event", v[7:0], 8'h40);
    wr(3'd1, 32'h0);
    rd(3'd1, v); chk("R5 cleared", v[7:0], 8'h00);

    // R9 event inputs
    @(negedge clk);
    ev_grf_ader = 1'b1;
    @(negedge clk);
    ev_grf_ader = 1'b0; ev_vid_tmo = 1'b1;
    @(negedge clk);
    ev_vid_tmo = 1'b0;
    repeat (2) @(negedge clk);
    rd(3'd1, v); chk("R9 grf and vid tmo sticky", v[7:0], 8'h18);
    @(negedge clk);
    ev_vid_ader = 1'b1; ev_cpu_tmo = 1'b1;
    @(negedge clk);
    ev_vid_ader = 1'b0; ev_cpu_tmo = 1'b0;
    rd(3'd1, v); chk("R9 vid ader and cpu tmo", v[7:0], 8'h3C);
    wr(3'd1, 32'h0);

    // R10 log registers read-only
    wr(3'd7, 32'h0000_FFFF);
    wr(3'd4, 32'h1234_5678);
    rd(3'd7, v); chk("R10 addr ignored", v, 32'h0000_2000);
    rd(3'd4, v); chk("R10 hi ignored", v, 32'hDEAD_BEEF);

    // R7 interrupt word on falling edge only
    wr(3'd2, 32'h0000_0840);
    repeat (3) @(negedge clk);
    chk("R7 steady high quiet", eir_valid, 1'b0);
    irq_n = 1'b0;
    @(negedge clk);
    chk("R7 strobe", eir_valid, 1'b1);
    chk("R7 word", eir_word, 32'h0000_0840);
    @(negedge clk);
    chk("R7 one cycle", eir_valid, 1'b0);
    repeat (3) @(negedge clk);
    chk("R7 steady low quiet", eir_valid, 1'b0);
    irq_n = 1'b1;
    @(negedge clk);
    chk("R7 rising quiet", eir_valid, 1'b0);
    @(negedge clk);
    chk("R7 after rise quiet", eir_valid, 1'b0);

    // R8 command reset
    wr(3'd0, 32'h1);
    ev_toc = 1'b1;
    @(negedge clk);
    ev_toc = 1'b0;
    cmd_rst = 1'b1;
    @(negedge clk);
    cmd_rst = 1'b0;
    rd(3'd1, v); chk("R8 cmdrst flag", v, {REV, 8'h80});
    rd(3'd0, v); chk("R8 ctrl cleared", v, 32'h0);
    rd(3'd3, v); chk("R8 limit restored", v, 32'hFFC0_0000);
    rd(3'd2, v); chk("R8 iword cleared", v, 32'h0);
    rd(3'd7, v); chk("R8 log cleared", v, 32'h0);
    wr(3'd1, 32'h0);
    rd(3'd1, v); chk("R8 flag survives status write", v[7:0], 8'h80);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(3'd1, v); chk("R8 hard reset clears", v[7:0], 8'h00);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule